// File: doc/BRIEF.md
# Segment Permission and Fault Classifier

This block sits in the translation path of a 32-bit processor's memory unit. Each request carries an effective address, an access kind (fetch, load or store), a privilege flag and a translation-enable flag. The block picks a segment descriptor from a sixteen-entry file, using the top four address bits. It decides the access rights and either produces the real address or classifies the fault. The hashed page-table walk and the block-translation lookup run elsewhere. Their hit flags, protection codes and addresses arrive as inputs.

A descriptor holds a direct-store flag, two key bits (one for each privilege level), a no-execute bit and a bus-unit field. Page rights come from a 2-bit protection code combined with the key that the privilege level selects. Each fault cause has a fixed status word, and the word depends on whether the access was a fetch, a load or a store. Data faults also capture the faulting address.

The control is a two-state machine. `S_IDLE` waits for a request. `S_REPORT` presents the registered result for one cycle. The transitions are: `S_IDLE`→`S_REPORT` when a request arrives, `S_REPORT`→`S_REPORT` when a request arrives back to back, and `S_REPORT`→`S_IDLE` when no request arrives.

Top module: `seg_perm_classifier`

## Requirements
- R1: After reset, `done`, `ok`, `ifault` and `dfault` are 0, and `fstat` and `far` are 0.
- R2: With `xlate_en`=0 the result is `ok`=1, `pa`=`ea` and `rights`=3'b111. The encoding of `rights` is bit0 read, bit1 write, bit2 execute. A fetch needs execute, a load needs read and a store needs write.
- R3: Descriptor fields are: bit31 direct-store, bit30 supervisor key, bit29 user key, bit28 no-execute, and bits[28:20] bus-unit ID (read only when direct-store is set). The key is bit29 when `priv`=0 and bit30 when `priv`=1.
- R4: Page rights with key 0 are read+write for codes 0, 1 and 2, and read only for code 3. With key 1, code 0 gives nothing, codes 1 and 3 give read only, and code 2 gives read+write. Execute is added only when the no-execute bit is clear.
- R5: A fetch from a segment whose no-execute bit is set gives `ifault`, with `fstat`=0x10000000.
- R6: On a page-table hit with enough rights, `pa`={`pt_rpn`, `ea[11:0]`}. On a miss, a fetch gives `fstat`=0x40000000, a load gives 0x40000000 and a store gives 0x42000000.
- R7: When the rights lack the needed one, a fetch gives `fstat`=0x08000000, a load gives 0x08000000 and a store gives 0x0A000000.
- R8: A direct-store segment with bus-unit ID 0x07F gives `ok`, `pa`={desc[3:0], `ea[27:0]`} and `rights`=3'b111, with no checks.
- R9: Other direct-store segments fault any fetch with `fstat`=0x10000000. Data accesses get `pa`=`ea` and rights of read+write when the key is 1, or read only when the key is 0. A denied store gets the R7 status.
- R10: `bt_hit`=1 takes precedence over the segment path. The rights are then `bt_rights`, `pa`=`bt_pa`, and a missing right gives the R7 status.
- R11: Every fault loads `fstat`. A data fault also loads `far`=`ea`. An instruction fault leaves `far` unchanged. On a fault, `ok`=0, `pa`=0 and `rights`=0, and exactly one of `ifault`/`dfault` is set.
- R12: `done` is 1 in the cycle after each cycle with `req_valid`=1, and 0 otherwise.
- R13: `seg_we`=1 writes `seg_wdata` into entry `seg_widx`. Requests use entry `ea[31:28]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seg_we | input | 1 | Descriptor write enable |
| seg_widx | input | 4 | Descriptor write index |
| seg_wdata | input | 32 | Descriptor write data |
| req_valid | input | 1 | Request strobe |
| ea | input | 32 | Effective address |
| acc | input | 2 | 0 fetch, 1 load, 2 store |
| priv | input | 1 | 1 = privileged |
| xlate_en | input | 1 | Translation enabled |
| bt_hit | input | 1 | Block-translation hit |
| bt_pa | input | 32 | Block-translation real address |
| bt_rights | input | 3 | Block-translation rights |
| pt_hit | input | 1 | Page-table hit |
| pt_pp | input | 2 | Page protection code |
| pt_rpn | input | 20 | Real page number |
| done | output | 1 | Result valid |
| ok | output | 1 | Access allowed |
| pa | output | 32 | Real address |
| rights | output | 3 | Granted rights |
| ifault | output | 1 | Instruction fault |
| dfault | output | 1 | Data fault |
| fstat | output | 32 | Fault status word |
| far | output | 32 | Faulting data address |

## Verification
Every result is registered on the clock edge that accepts the request, so it is due exactly one cycle later, while `done` is high. The bench drives a request on a falling edge, removes it at the next falling edge and compares all outputs at that point, after exactly one rising edge. Descriptor writes are completed one cycle before the requests that use them. The checker looks at the inputs as they were one cycle earlier, at the same one-cycle offset.

// File: rtl/seg_perm_pkg.sv
package seg_perm_pkg;
    typedef enum logic [1:0] { ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2 } acc_t;
    typedef enum logic [1:0] { C_NONE, C_NOEXEC, C_MISS, C_PROT } cause_t;
    typedef enum logic { S_IDLE, S_REPORT } state_t;

    localparam logic [31:0] ST_NOEXEC  = 32'h1000_0000;
    localparam logic [31:0] ST_MISS    = 32'h4000_0000;
    localparam logic [31:0] ST_MISS_WR = 32'h4200_0000;
    localparam logic [31:0] ST_PROT    = 32'h0800_0000;
    localparam logic [31:0] ST_PROT_WR = 32'h0A00_0000;
    localparam logic [8:0]  FORCED_BUS = 9'h07F;

    function automatic logic [2:0] need_of(input logic [1:0] a);
        case (a)
            ACC_FETCH: need_of = 3'b100;
            ACC_LOAD:  need_of = 3'b001;
            default:   need_of = 3'b010;
        endcase
    endfunction
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file #(
    parameter int N_SEG = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(N_SEG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [N_SEG];

    for (genvar g = 0; g < N_SEG; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              mem[g] <= '0;
            else if (we && widx == IW'(g))           mem[g] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/page_rights_dec.sv
module page_rights_dec (
    input  logic [1:0] pp,
    input  logic       key,
    input  logic       nx,
    output logic [2:0] rights
);
    logic [1:0] rw;
    always_comb begin
        unique case ({key, pp})
            3'b0_00, 3'b0_01, 3'b0_10: rw = 2'b11;
            3'b0_11:                   rw = 2'b01;
            3'b1_00:                   rw = 2'b00;
            3'b1_10:                   rw = 2'b11;
            default:                   rw = 2'b01;
        endcase
        rights = {~nx, rw};
    end
endmodule

// File: rtl/fault_word_enc.sv
module fault_word_enc
    import seg_perm_pkg::*;
(
    input  cause_t      cause,
    input  logic [1:0]  acc,
    output logic        is_ifault,
    output logic        is_dfault,
    output logic [31:0] word
);
    logic fetch, store;
    assign fetch = (acc == ACC_FETCH);
    assign store = (acc == ACC_STORE);
    always_comb begin
        is_ifault = (cause != C_NONE) && fetch;
        is_dfault = (cause != C_NONE) && !fetch;
        unique case (cause)
            C_NOEXEC: word = ST_NOEXEC;
            C_MISS:   word = store ? ST_MISS_WR : ST_MISS;
            C_PROT:   word = store ? ST_PROT_WR : ST_PROT;
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/seg_perm_classifier.sv
module seg_perm_classifier
    import seg_perm_pkg::*;
#(
    parameter int N_SEG     = 16,
    parameter int PAGE_BITS = 12,
    localparam int IW       = $clog2(N_SEG),
    localparam int RPN_W    = 32 - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_we,
    input  logic [IW-1:0]    seg_widx,
    input  logic [31:0]      seg_wdata,
    input  logic             req_valid,
    input  logic [31:0]      ea,
    input  logic [1:0]       acc,
    input  logic             priv,
    input  logic             xlate_en,
    input  logic             bt_hit,
    input  logic [31:0]      bt_pa,
    input  logic [2:0]       bt_rights,
    input  logic             pt_hit,
    input  logic [1:0]       pt_pp,
    input  logic [RPN_W-1:0] pt_rpn,
    output logic             done,
    output logic             ok,
    output logic [31:0]      pa,
    output logic [2:0]       rights,
    output logic             ifault,
    output logic             dfault,
    output logic [31:0]      fstat,
    output logic [31:0]      far
);
    state_t state, state_nx;
    logic [31:0] desc;
    logic        key, ds_forced;
    logic [2:0]  pg_rights, need, c_rights;
    logic [31:0] c_pa, f_word;
    cause_t      cause;
    logic        f_i, f_d;

    seg_desc_file #(.N_SEG(N_SEG), .DW(32)) u_seg (
        .clk(clk), .rst_n(rst_n), .we(seg_we), .widx(seg_widx), .wdata(seg_wdata),
        .ridx(ea[31 -: IW]), .rdata(desc)
    );

    assign key       = priv ? desc[30] : desc[29];
    assign ds_forced = (desc[28:20] == FORCED_BUS);
    assign need      = need_of(acc);

    page_rights_dec u_pr (.pp(pt_pp), .key(key), .nx(desc[28]), .rights(pg_rights));

    always_comb begin
        cause    = C_NONE;
        c_rights = 3'b000;
        c_pa     = ea;
        if (!xlate_en) begin
            c_rights = 3'b111;
        end else if (bt_hit) begin
            c_rights = bt_rights;
            c_pa     = bt_pa;
            if ((need & ~bt_rights) != 3'b000) cause = C_PROT;
        end else if (desc[31]) begin
            if (ds_forced) begin
                c_rights = 3'b111;
                c_pa     = {desc[3:0], ea[27:0]};
            end else if (acc == ACC_FETCH) begin
                cause = C_NOEXEC;
            end else begin
                c_rights = key ? 3'b011 : 3'b001;
                if ((need & ~c_rights) != 3'b000) cause = C_PROT;
            end
        end else if (acc == ACC_FETCH && desc[28]) begin
            cause = C_NOEXEC;
        end else if (!pt_hit) begin
            cause = C_MISS;
        end else begin
            c_rights = pg_rights;
            c_pa     = {pt_rpn, ea[PAGE_BITS-1:0]};
            if ((need & ~pg_rights) != 3'b000) cause = C_PROT;
        end
    end

    fault_word_enc u_fw (.cause(cause), .acc(acc), .is_ifault(f_i), .is_dfault(f_d), .word(f_word));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            S_IDLE:   state_nx = req_valid ? S_REPORT : S_IDLE;
            S_REPORT: state_nx = req_valid ? S_REPORT : S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    assign done = (state == S_REPORT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok <= 1'b0; pa <= '0; rights <= '0;
            ifault <= 1'b0; dfault <= 1'b0; fstat <= '0; far <= '0;
        end else if (req_valid) begin
            ok     <= (cause == C_NONE);
            pa     <= (cause == C_NONE) ? c_pa : 32'h0;
            rights <= (cause == C_NONE) ? c_rights : 3'b000;
            ifault <= f_i;
            dfault <= f_d;
            if (cause != C_NONE) fstat <= f_word;
            if (f_d)             far   <= ea;
        end else begin
            ok <= 1'b0; ifault <= 1'b0; dfault <= 1'b0;
        end
    end
endmodule

// File: rtl/seg_perm_classifier_chk.sv
module seg_perm_classifier_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] ea,
    input logic [1:0]  acc,
    input logic        xlate_en,
    input logic        done,
    input logic        ok,
    input logic [31:0] pa,
    input logic [2:0]  rights,
    input logic        ifault,
    input logic        dfault,
    input logic [31:0] fstat,
    input logic [31:0] far
);
    a_r12_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    a_r12_no_done_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);
    a_r11_one_fault_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok, ifault, dfault}));
    a_r2_real_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlate_en) |=> (ok && pa == $past(ea) && rights == 3'b111));
    a_r11_far_capture: assert property (@(posedge clk) disable iff (!rst_n)
        dfault |-> far == $past(ea));
    a_r11_far_hold_ifault: assert property (@(posedge clk) disable iff (!rst_n)
        ifault |-> $stable(far));
    a_r11_fault_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (ifault || dfault) |-> (pa == 32'h0 && rights == 3'b000 && fstat != 32'h0));
    a_r11_ifault_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        ifault |-> $past(acc) == 2'd0);
endmodule

bind seg_perm_classifier seg_perm_classifier_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ea(ea), .acc(acc),
    .xlate_en(xlate_en), .done(done), .ok(ok), .pa(pa), .rights(rights),
    .ifault(ifault), .dfault(dfault), .fstat(fstat), .far(far)
);

// File: tb/seg_perm_classifier_tb.sv
module seg_perm_classifier_tb_top;
    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic seg_we = 0; logic [3:0] seg_widx = 0; logic [31:0] seg_wdata = 0;
    logic req_valid = 0; logic [31:0] ea = 0; logic [1:0] acc = 0;
    logic priv = 0, xlate_en = 0, bt_hit = 0, pt_hit = 0;
    logic [31:0] bt_pa = 0; logic [2:0] bt_rights = 0; logic [1:0] pt_pp = 0;
    logic [19:0] pt_rpn = 0;
    logic done, ok, ifault, dfault; logic [31:0] pa, fstat, far; logic [2:0] rights;

    seg_perm_classifier dut_i (.*);

    int n_chk = 0, n_fail = 0;
    logic [31:0] segs [16];
    logic [31:0] far_model = 0, fstat_model = 0;

    task automatic chk(input bit good, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] seg_val(input int i);
        if (i < 8)       return {1'b0, i[0] ^ i[1], i[1], i[2], 4'h0, 24'h000100 + 24'(i)};
        else if (i < 12) return {1'b1, i[0], i[1], 9'h015, 20'h00000 + 20'(i)};
        else             return {1'b1, i[0], i[1], 9'h07F, 16'h0, 4'(i * 3)};
    endfunction

    task automatic seg_write(input int i, input logic [31:0] v);
        @(negedge clk);
        seg_we = 1; seg_widx = 4'(i); seg_wdata = v;
        @(negedge clk);
        seg_we = 0;
        segs[i] = v;
    endtask

    // Reference model from the requirements; codes: acc 0 fetch 1 load 2 store, rights bit0 r bit1 w bit2 x
    task automatic model(output bit e_ok, output logic [31:0] e_pa, output logic [2:0] e_r,
                         output bit e_if, output bit e_df, output logic [31:0] e_st);
        logic [31:0] d; logic k; logic [2:0] nd, r; int cz;  // cz: 0 none,1 noexec,2 miss,3 prot
        d = segs[ea[31:28]];
        k = priv ? d[30] : d[29];
        nd = (acc == 0) ? 3'b100 : (acc == 1) ? 3'b001 : 3'b010;
        cz = 0; r = 0; e_pa = ea;
        if (!xlate_en) r = 3'b111;
        else if (bt_hit) begin r = bt_rights; e_pa = bt_pa; if ((nd & ~r) != 0) cz = 3; end
        else if (d[31]) begin
            if (d[28:20] == 9'h07F) begin r = 3'b111; e_pa = {d[3:0], ea[27:0]}; end
            else if (acc == 0) cz = 1;
            else begin r = k ? 3'b011 : 3'b001; if ((nd & ~r) != 0) cz = 3; end
        end
        else if (acc == 0 && d[28]) cz = 1;
        else if (!pt_hit) cz = 2;
        else begin
            if (!k) r[1:0] = (pt_pp == 3) ? 2'b01 : 2'b11;
            else    r[1:0] = (pt_pp == 0) ? 2'b00 : (pt_pp == 2) ? 2'b11 : 2'b01;
            r[2] = !d[28];
            e_pa = {pt_rpn, ea[11:0]};
            if ((nd & ~r) != 0) cz = 3;
        end
        e_ok = (cz == 0); e_if = (cz != 0) && acc == 0; e_df = (cz != 0) && acc != 0;
        case (cz)
            1: e_st = 32'h1000_0000;
            2: e_st = (acc == 2) ? 32'h4200_0000 : 32'h4000_0000;
            3: e_st = (acc == 2) ? 32'h0A00_0000 : 32'h0800_0000;
            default: e_st = fstat_model;
        endcase
        if (!e_ok) begin e_pa = 0; e_r = 0; fstat_model = e_st; end else e_r = r;
        if (e_df) far_model = ea;
    endtask

    task automatic run_req(input string tag);
        bit e_ok, e_if, e_df; logic [31:0] e_pa, e_st; logic [2:0] e_r;
        model(e_ok, e_pa, e_r, e_if, e_df, e_st);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(done === 1'b1, {tag, " R12 done"}, 64'(done), 64'd1);
        chk(ok === e_ok && ifault === e_if && dfault === e_df,
            {tag, " R11 outcome"}, {61'd0, ok, ifault, dfault}, {61'd0, e_ok, e_if, e_df});
        chk(pa === e_pa && rights === e_r, {tag, " R4 R6 pa/rights"}, {29'd0, rights, pa}, {29'd0, e_r, e_pa});
        chk(fstat === fstat_model, {tag, " R6 R7 fstat"}, 64'(fstat), 64'(fstat_model));
        chk(far === far_model, {tag, " R11 far"}, 64'(far), 64'(far_model));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) segs[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(done === 0 && ok === 0 && ifault === 0 && dfault === 0 && fstat === 0 && far === 0,
            "R1 reset", {30'd0, done, ok, fstat}, 64'd0);
        for (int i = 0; i < 16; i++) seg_write(i, seg_val(i));     // R13 segment file
        xlate_en = 0; ea = 32'hDEAD_B00F; acc = 2; run_req("R2 real mode store");
        ea = 32'h1234_5678; acc = 0; run_req("R2 real mode fetch");
        xlate_en = 1;
        for (int s = 0; s < 16; s++)
            for (int p = 0; p < 2; p++)
                for (int a = 0; a < 3; a++)
                    for (int q = 0; q < 4; q++)
                        for (int h = 0; h < 4; h++) begin
                            ea = {4'(s), 28'h0ABC000 + 28'(q * 4099 + a * 17 + h)};
                            priv = p[0]; acc = 2'(a); pt_pp = 2'(q);
                            pt_hit = h[0]; bt_hit = h[1] & (s[0] ^ q[0]);
                            bt_rights = 3'(q + a + s); bt_pa = {4'hB, 28'(s * 257 + q)};
                            pt_rpn = 20'(s * 4111 + q * 33 + a);
                            run_req("R3 R4 R5 R8 R9 R10 sweep");
                        end
        // R13: rewrite entry 3 to no-execute, expect fetch fault R5
        seg_write(3, 32'h1000_0003);
        bt_hit = 0; pt_hit = 1; acc = 0; ea = 32'h3000_1000; run_req("R5 R13 rewritten nx");
        // R11: data fault then instruction fault keeps far
        acc = 1; pt_hit = 0; ea = 32'h5000_2344; run_req("R11 data fault");
        acc = 0; ea = 32'h9000_0000; run_req("R11 ifault keeps far");
        @(negedge clk);
        chk(done === 0, "R12 done drops", 64'(done), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R12 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule